// File: doc/BRIEF.md
# Management Bus Frame Monitor

This block listens passively to the two-wire station management bus between an Ethernet MAC and its PHYs and decodes every frame it sees. The clock and data lines come in unsynchronised. The block resamples them in the system clock domain and takes one data bit at each rising edge of the management clock. Both the short-address frame format (five-bit PHY and register addresses) and the extended format (five-bit port and device addresses with a separately loaded 16-bit register address) are accepted in the same decoder.

Each completed read or write frame produces a single-cycle record strobe with these fields:
- the format flag, the read flag, both five-bit addresses and the 16-bit data;
- opcode and turnaround error flags;
- for extended frames, the register address currently tracked by the monitor.

Extended address frames produce no record. They load the tracked register address instead, and read-with-increment frames advance it. Problems at the bus level are reported on separate strobes: a shortened preamble, an illegal low level seen outside a frame, and the length of any idle run of ones.

Top module: `mgmt_frame_monitor`

## Requirements
- R1: A data bit is taken only at a rising edge of `mdc_in`. Changes on `mdio_in` while `mdc_in` stays high have no effect.
- R2: A frame is preceded by a run of ones. A zero after 1 to 31 ones pulses `err_short_pre` for one cycle, and that zero still acts as the first start bit, so the frame is decoded normally.
- R3: When a zero follows more than 32 ones, `idle_valid` pulses for one cycle with `idle_len` equal to the number of ones minus 32. This is not an error, and `err_short_pre` stays low.
- R4: A zero seen with no preceding ones enters an illegal state. Further zeros keep the block in that state. The next one pulses `err_illegal` once and counts as the first preamble one.
- R5: The bit after the start zero selects the format: 0 selects the extended format (`rec_c45`=1) and 1 selects the short format (`rec_c45`=0).
- R6: The two opcode bits follow, first bit sent as bit 1. `rec_read` equals the first opcode bit. Extended opcodes are 00 address, 01 write, 10 read with increment and 11 read. In the short format 10 is read and 01 is write; 00 and 11 set `rec_op_err`.
- R7: The port/PHY address (5 bits), the device/register address (5 bits) and, after the two turnaround bits, the 16 data bits are all shifted in MSB first.
- R8: `rec_ta_err[0]` is set when the first turnaround bit is 0 in a frame whose first opcode bit is 0. `rec_ta_err[1]` is set when the second turnaround bit is 1, in any frame. Both can be set together.
- R9: An extended frame with opcode 00 produces no record strobe. It loads its 16 data bits into the tracked register address.
- R10: The tracked address is unknown after reset and becomes known at the first extended address frame. Extended records carry the tracked address and its known flag as they stood before the frame. An extended read-with-increment frame adds one to a known address. Short-format records report address 0 and known 0.
- R11: `rec_valid` is a single-cycle strobe raised once per completed non-address frame, at the 16th data bit. After that bit the block returns to preamble search with its ones count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_in | input | 1 | Management clock, asynchronous |
| mdio_in | input | 1 | Management data, asynchronous |
| rec_valid | output | 1 | One-cycle strobe for a decoded record |
| rec_c45 | output | 1 | 1 for the extended format |
| rec_read | output | 1 | 1 for a read frame |
| rec_port | output | 5 | Port/PHY address |
| rec_dev | output | 5 | Device/register address |
| rec_data | output | 16 | Data field |
| rec_addr | output | 16 | Tracked register address (extended format) |
| rec_addr_known | output | 1 | Tracked address is valid |
| rec_op_err | output | 1 | Invalid short-format opcode |
| rec_ta_err | output | 2 | Turnaround errors: [0] first bit, [1] second bit |
| err_short_pre | output | 1 | One-cycle strobe: preamble shorter than 32 ones |
| err_illegal | output | 1 | One-cycle strobe: leaving the illegal low state |
| idle_valid | output | 1 | One-cycle strobe: idle ones preceded this frame |
| idle_len | output | 16 | Ones beyond 32 in the preamble just ended |

## Verification
A bit counter that slips by one in any field shows up at the next record as shifted port, device or data values, or as a missing `rec_valid` strobe. Because the decoder resynchronises only at the next preamble, a wrong ones count or a wrong illegal flag shows up on the bus error strobes, or as a lost frame, at the start bit of the following frame. A fault in the address tracker stays hidden until the next extended record. That record then reports an address or known flag that differs from the bench's running model, so the bench interleaves address, increment and plain read frames.

// File: rtl/mfm_pkg.sv
package mfm_pkg;
  typedef enum logic [2:0] {
    S_PRE, S_ST, S_OP, S_PAD, S_DAD, S_TA, S_DAT
  } mfm_state_e;

  localparam int PRE_LEN = 32;

  localparam logic [1:0] OP_ADDR = 2'b00;
  localparam logic [1:0] OP_RINC = 2'b10;
endpackage

// File: rtl/mfm_sync_edge.sv
module mfm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_in,
  input  logic mdio_in,
  output logic rst_sn,
  output logic bit_stb,
  output logic bit_val
);
  logic [1:0]      rst_pipe;
  logic [STAGES:0] mdc_sh;
  logic [STAGES-1:0] mdio_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mdc_sh  <= '0;
      mdio_sh <= '0;
    end else begin
      mdc_sh  <= {mdc_sh[STAGES-1:0], mdc_in};
      mdio_sh <= {mdio_sh[STAGES-2:0], mdio_in};
    end
  end

  assign bit_stb = mdc_sh[STAGES-1] & ~mdc_sh[STAGES];
  assign bit_val = mdio_sh[STAGES-1];

  assert_edge_gap_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/mfm_addr_track.sv
module mfm_addr_track
  import mfm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_stb,
  input  logic              upd_c45,
  input  logic [1:0]        upd_op,
  input  logic [DATA_W-1:0] upd_data,
  output logic [DATA_W-1:0] addr,
  output logic              known
);
  logic [DATA_W-1:0] addr_q, addr_d;
  logic              known_q, known_d;

  always_comb begin
    addr_d  = addr_q;
    known_d = known_q;
    if (upd_stb && upd_c45) begin
      if (upd_op == OP_ADDR) begin
        addr_d  = upd_data;
        known_d = 1'b1;
      end else if (upd_op == OP_RINC && known_q) begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      known_q <= 1'b0;
    end else if (upd_stb) begin
      addr_q  <= addr_d;
      known_q <= known_d;
    end
  end

  assign addr  = addr_q;
  assign known = known_q;

  assert_known_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    known |=> known);
  assert_post_inc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && upd_c45 && upd_op == OP_RINC && known) |=> addr == $past(addr) + 1'b1);
  assert_addr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && upd_c45 && upd_op == OP_ADDR) |=> (known && addr == $past(upd_data)));
endmodule

// File: rtl/mfm_frame_fsm.sv
module mfm_frame_fsm
  import mfm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic [DATA_W-1:0] trk_addr,
  input  logic              trk_known,
  output logic              done_stb,
  output logic              done_c45,
  output logic [1:0]        done_op,
  output logic [DATA_W-1:0] done_data,
  output logic              rec_valid,
  output logic              rec_c45,
  output logic              rec_read,
  output logic [ADDR_W-1:0] rec_port,
  output logic [ADDR_W-1:0] rec_dev,
  output logic [DATA_W-1:0] rec_data,
  output logic [DATA_W-1:0] rec_addr,
  output logic              rec_addr_known,
  output logic              rec_op_err,
  output logic [1:0]        rec_ta_err,
  output logic              err_short_pre,
  output logic              err_illegal,
  output logic              idle_valid,
  output logic [CNT_W-1:0]  idle_len
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0]    LAST_A = CW'(ADDR_W - 1);
  localparam logic [CW-1:0]    LAST_D = CW'(DATA_W - 1);
  localparam logic [CNT_W-1:0] PRE_C  = CNT_W'(PRE_LEN);

  mfm_state_e        state_q, state_d;
  logic [CNT_W-1:0]  ones_q, ones_d;
  logic              ill_q, ill_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              c45_q, c45_d;
  logic [1:0]        op_q, op_d;
  logic [ADDR_W-1:0] port_q, port_d, dev_q, dev_d;
  logic [1:0]        ta_q, ta_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              short_d, illerr_d, idle_d, emit;
  logic [CNT_W-1:0]  idle_len_d;

  always_comb begin
    state_d    = state_q;
    ones_d     = ones_q;
    ill_d      = ill_q;
    cnt_d      = cnt_q;
    c45_d      = c45_q;
    op_d       = op_q;
    port_d     = port_q;
    dev_d      = dev_q;
    ta_d       = ta_q;
    data_d     = data_q;
    short_d    = 1'b0;
    illerr_d   = 1'b0;
    idle_d     = 1'b0;
    idle_len_d = idle_len;
    done_stb   = 1'b0;
    if (bit_stb) begin
      unique case (state_q)
        S_PRE: begin
          if (ill_q) begin
            if (bit_val) begin
              ill_d    = 1'b0;
              illerr_d = 1'b1;
              ones_d   = CNT_W'(1);
            end
          end else if (bit_val) begin
            if (ones_q != '1) ones_d = ones_q + 1'b1;
          end else if (ones_q == '0) begin
            ill_d = 1'b1;
          end else begin
            short_d = (ones_q < PRE_C);
            if (ones_q > PRE_C) begin
              idle_d     = 1'b1;
              idle_len_d = ones_q - PRE_C;
            end
            state_d = S_ST;
          end
        end
        S_ST: begin
          c45_d   = ~bit_val;
          cnt_d   = '0;
          state_d = S_OP;
        end
        S_OP: begin
          op_d = {op_q[0], bit_val};
          if (cnt_q == CW'(1)) begin
            cnt_d   = '0;
            state_d = S_PAD;
          end else cnt_d = cnt_q + 1'b1;
        end
        S_PAD: begin
          port_d = {port_q[ADDR_W-2:0], bit_val};
          if (cnt_q == LAST_A) begin
            cnt_d   = '0;
            state_d = S_DAD;
          end else cnt_d = cnt_q + 1'b1;
        end
        S_DAD: begin
          dev_d = {dev_q[ADDR_W-2:0], bit_val};
          if (cnt_q == LAST_A) begin
            cnt_d   = '0;
            ta_d    = '0;
            state_d = S_TA;
          end else cnt_d = cnt_q + 1'b1;
        end
        S_TA: begin
          if (cnt_q == '0) begin
            ta_d[0] = ~op_q[1] & ~bit_val;
            cnt_d   = CW'(1);
          end else begin
            ta_d[1] = bit_val;
            cnt_d   = '0;
            state_d = S_DAT;
          end
        end
        S_DAT: begin
          data_d = {data_q[DATA_W-2:0], bit_val};
          if (cnt_q == LAST_D) begin
            done_stb = 1'b1;
            ones_d   = '0;
            ill_d    = 1'b0;
            state_d  = S_PRE;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: state_d = S_PRE;
      endcase
    end
  end

  assign emit      = done_stb && !(c45_q && op_q == OP_ADDR);
  assign done_c45  = c45_q;
  assign done_op   = op_q;
  assign done_data = data_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_PRE;
      ones_q  <= '0;
      ill_q   <= 1'b0;
      cnt_q   <= '0;
      c45_q   <= 1'b0;
      op_q    <= '0;
      port_q  <= '0;
      dev_q   <= '0;
      ta_q    <= '0;
      data_q  <= '0;
    end else if (bit_stb) begin
      state_q <= state_d;
      ones_q  <= ones_d;
      ill_q   <= ill_d;
      cnt_q   <= cnt_d;
      c45_q   <= c45_d;
      op_q    <= op_d;
      port_q  <= port_d;
      dev_q   <= dev_d;
      ta_q    <= ta_d;
      data_q  <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid     <= 1'b0;
      err_short_pre <= 1'b0;
      err_illegal   <= 1'b0;
      idle_valid    <= 1'b0;
      idle_len      <= '0;
    end else begin
      rec_valid     <= emit;
      err_short_pre <= short_d;
      err_illegal   <= illerr_d;
      idle_valid    <= idle_d;
      idle_len      <= idle_len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_c45        <= 1'b0;
      rec_read       <= 1'b0;
      rec_port       <= '0;
      rec_dev        <= '0;
      rec_data       <= '0;
      rec_addr       <= '0;
      rec_addr_known <= 1'b0;
      rec_op_err     <= 1'b0;
      rec_ta_err     <= '0;
    end else if (emit) begin
      rec_c45        <= c45_q;
      rec_read       <= op_q[1];
      rec_port       <= port_q;
      rec_dev        <= dev_q;
      rec_data       <= data_d;
      rec_addr       <= c45_q ? trk_addr : '0;
      rec_addr_known <= c45_q & trk_known;
      rec_op_err     <= ~c45_q & (op_q[1] == op_q[0]);
      rec_ta_err     <= ta_q;
    end
  end

  assert_rec_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);
  assert_short_not_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_short_pre && idle_valid));
  assert_ill_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |=> !err_illegal);
  assert_idle_positive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idle_valid |-> idle_len != '0);
endmodule

// File: rtl/mgmt_frame_monitor.sv
module mgmt_frame_monitor #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_in,
  input  logic              mdio_in,
  output logic              rec_valid,
  output logic              rec_c45,
  output logic              rec_read,
  output logic [ADDR_W-1:0] rec_port,
  output logic [ADDR_W-1:0] rec_dev,
  output logic [DATA_W-1:0] rec_data,
  output logic [DATA_W-1:0] rec_addr,
  output logic              rec_addr_known,
  output logic              rec_op_err,
  output logic [1:0]        rec_ta_err,
  output logic              err_short_pre,
  output logic              err_illegal,
  output logic              idle_valid,
  output logic [CNT_W-1:0]  idle_len
);
  logic              rst_sn, bit_stb, bit_val;
  logic              done_stb, done_c45;
  logic [1:0]        done_op;
  logic [DATA_W-1:0] done_data, trk_addr;
  logic              trk_known;

  mfm_sync_edge #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .mdc_in(mdc_in), .mdio_in(mdio_in),
    .rst_sn(rst_sn), .bit_stb(bit_stb), .bit_val(bit_val)
  );

  mfm_addr_track #(.DATA_W(DATA_W)) u_track (
    .clk(clk), .rst_n(rst_sn), .upd_stb(done_stb), .upd_c45(done_c45),
    .upd_op(done_op), .upd_data(done_data), .addr(trk_addr), .known(trk_known)
  );

  mfm_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_sn), .bit_stb(bit_stb), .bit_val(bit_val),
    .trk_addr(trk_addr), .trk_known(trk_known),
    .done_stb(done_stb), .done_c45(done_c45), .done_op(done_op), .done_data(done_data),
    .rec_valid(rec_valid), .rec_c45(rec_c45), .rec_read(rec_read),
    .rec_port(rec_port), .rec_dev(rec_dev), .rec_data(rec_data),
    .rec_addr(rec_addr), .rec_addr_known(rec_addr_known),
    .rec_op_err(rec_op_err), .rec_ta_err(rec_ta_err),
    .err_short_pre(err_short_pre), .err_illegal(err_illegal),
    .idle_valid(idle_valid), .idle_len(idle_len)
  );
endmodule

// File: tb/mgmt_frame_monitor_test.sv
`timescale 1ns/1ps
module mgmt_frame_monitor_test;
  logic clk, rst_n, mdc, mdio;
  logic rec_valid, rec_c45, rec_read, rec_addr_known, rec_op_err;
  logic [4:0] rec_port, rec_dev;
  logic [15:0] rec_data, rec_addr, idle_len;
  logic [1:0] rec_ta_err;
  logic err_short_pre, err_illegal, idle_valid;

  mgmt_frame_monitor uut (
    .clk(clk), .rst_n(rst_n), .mdc_in(mdc), .mdio_in(mdio),
    .rec_valid(rec_valid), .rec_c45(rec_c45), .rec_read(rec_read),
    .rec_port(rec_port), .rec_dev(rec_dev), .rec_data(rec_data),
    .rec_addr(rec_addr), .rec_addr_known(rec_addr_known),
    .rec_op_err(rec_op_err), .rec_ta_err(rec_ta_err),
    .err_short_pre(err_short_pre), .err_illegal(err_illegal),
    .idle_valid(idle_valid), .idle_len(idle_len)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  int n_rec = 0, n_short = 0, n_ill = 0, n_idle = 0;
  logic [15:0] last_idle;
  logic c_c45, c_read, c_known, c_operr;
  logic [4:0] c_port, c_dev;
  logic [15:0] c_data, c_addr;
  logic [1:0] c_ta;

  logic [15:0] m_addr;
  logic m_known;

  always @(negedge clk) begin
    if (rec_valid) begin
      n_rec++;
      c_c45 = rec_c45; c_read = rec_read; c_port = rec_port; c_dev = rec_dev;
      c_data = rec_data; c_addr = rec_addr; c_known = rec_addr_known;
      c_operr = rec_op_err; c_ta = rec_ta_err;
    end
    if (err_short_pre) n_short++;
    if (err_illegal) n_ill++;
    if (idle_valid) begin n_idle++; last_idle = idle_len; end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input bit b);
    mdc = 1'b0; mdio = b;
    repeat (4) @(negedge clk);
    mdc = 1'b1;
    repeat (4) @(negedge clk);
    mdio = ~b;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [1:0] exp_ta(input logic [1:0] op, input logic [1:0] ta);
    return {ta[0], ~op[1] & ~ta[1]};
  endfunction

  function automatic bit exp_operr(input bit c45, input logic [1:0] op);
    return !c45 && (op[1] == op[0]);
  endfunction

  task automatic send_frame(input int zeros, input int pre, input bit c45, input logic [1:0] op,
                            input logic [4:0] port, input logic [4:0] dev,
                            input logic [1:0] ta, input logic [15:0] data);
    int r0;
    logic [15:0] ea;
    logic ek;
    r0 = n_rec;
    ea = m_addr; ek = m_known;
    for (int i = 0; i < zeros; i++) send_bit(1'b0);
    for (int i = 0; i < pre; i++) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(~c45);
    send_bit(op[1]); send_bit(op[0]);
    for (int i = 4; i >= 0; i--) send_bit(port[i]);
    for (int i = 4; i >= 0; i--) send_bit(dev[i]);
    send_bit(ta[1]); send_bit(ta[0]);
    for (int i = 15; i >= 0; i--) send_bit(data[i]);
    repeat (3) @(negedge clk);
    if (c45 && op == 2'b00) begin
      chk(n_rec == r0, "R9 no record for address frame", 64'(n_rec - r0), 0);
      m_addr = data; m_known = 1'b1;
    end else begin
      chk(n_rec == r0 + 1, "R11 one record per frame", 64'(n_rec - r0), 1);
      chk(c_c45 == c45 && c_read == op[1], "R5 R6 format and read flag",
          {c_c45, c_read}, {c45, op[1]});
      chk(c_operr == exp_operr(c45, op), "R6 opcode error", c_operr, exp_operr(c45, op));
      chk({c_port, c_dev, c_data} == {port, dev, data}, "R7 R1 fields",
          {c_port, c_dev, c_data}, {port, dev, data});
      chk(c_ta == exp_ta(op, ta), "R8 turnaround flags", c_ta, exp_ta(op, ta));
      if (c45)
        chk({c_known, c_addr} == {ek, ek ? ea : 16'h0}, "R10 tracked address",
            {c_known, c_addr}, {ek, ek ? ea : 16'h0});
      else
        chk({c_known, c_addr} == 17'h0, "R10 short format address", {c_known, c_addr}, 0);
      if (c45 && op == 2'b10 && m_known) m_addr = m_addr + 1'b1;
    end
  endtask

  function automatic logic [1:0] good_ta(input logic [1:0] op);
    return op[1] ? 2'b00 : 2'b10;
  endfunction

  task automatic run_all();
    int s0, i0, d0;
    void'($urandom(32'd2718));
    mdc = 1'b0; mdio = 1'b1; rst_n = 1'b0;
    m_addr = '0; m_known = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({rec_valid, err_short_pre, err_illegal, idle_valid} == 4'b0, "R11 reset state",
        {rec_valid, err_short_pre, err_illegal, idle_valid}, 0);

    i0 = n_ill;
    send_frame(3, 32, 1'b0, 2'b10, 5'h11, 5'h0A, 2'b00, 16'hBEEF);
    chk(n_ill == i0 + 1, "R4 illegal state reported once", 64'(n_ill - i0), 1);

    send_frame(0, 32, 1'b1, 2'b11, 5'h03, 5'h01, 2'b00, 16'h1234);
    send_frame(0, 32, 1'b1, 2'b10, 5'h03, 5'h01, 2'b00, 16'h1111);
    chk(m_known == 1'b0, "R10 unknown before load", m_known, 0);
    send_frame(0, 32, 1'b1, 2'b00, 5'h03, 5'h01, 2'b10, 16'hFFFE);
    send_frame(0, 32, 1'b1, 2'b10, 5'h03, 5'h01, 2'b00, 16'h2222);
    send_frame(0, 32, 1'b1, 2'b10, 5'h03, 5'h01, 2'b00, 16'h3333);
    send_frame(0, 32, 1'b1, 2'b01, 5'h03, 5'h01, 2'b10, 16'h4444);

    s0 = n_short;
    send_frame(0, 20, 1'b0, 2'b01, 5'h1F, 5'h00, 2'b10, 16'h5A5A);
    chk(n_short == s0 + 1, "R2 short preamble flagged", 64'(n_short - s0), 1);
    s0 = n_short;
    send_frame(0, 1, 1'b0, 2'b10, 5'h01, 5'h1F, 2'b00, 16'h0001);
    chk(n_short == s0 + 1, "R2 single-one preamble", 64'(n_short - s0), 1);

    d0 = n_idle; s0 = n_short;
    send_frame(0, 45, 1'b0, 2'b10, 5'h02, 5'h02, 2'b00, 16'h8000);
    chk(n_idle == d0 + 1 && last_idle == 16'd13, "R3 idle length",
        last_idle, 13);
    chk(n_short == s0, "R3 idle is not short", 64'(n_short - s0), 0);
    d0 = n_idle;
    send_frame(0, 32, 1'b0, 2'b00, 5'h04, 5'h05, 2'b01, 16'h00FF);
    chk(n_idle == d0 && n_short == s0, "R2 R3 exact preamble silent",
        64'(n_idle - d0), 0);
    send_frame(0, 32, 1'b0, 2'b11, 5'h04, 5'h05, 2'b01, 16'hF00F);

    for (int k = 0; k < 30; k++) begin
      logic c; logic [1:0] op, ta; logic [4:0] p, dv; logic [15:0] dt;
      c = 1'($urandom); op = 2'($urandom); p = 5'($urandom); dv = 5'($urandom);
      dt = 16'($urandom);
      ta = ($urandom % 4 == 0) ? 2'($urandom) : good_ta(op);
      send_frame(0, 32 + ($urandom % 3), c, op, p, dv, ta, dt);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule